// File: doc/BRIEF.md
# Qualified Ratio Clock Divider

This block slows the system clock by an integer ratio picked with a 4-bit code. Code zero leaves the divider out of the path, so the input clock appears at the output unchanged. A nonzero code N gives an output period of N+1 input cycles. The high phase opens each period and lasts floor((N+1)/2) input cycles.

The divider runs only when three things hold. The internal oscillator must be the selected source. Asynchronous fast-clock requests must be blocked. The oscillator must have reported its base frequency for a minimum number of cycles. If any of these fails, the divider drops to bypass on the next edge. Code changes made while the divider runs are held until the current output period ends, so the output never shows a shortened high or low phase. When the divider turns off, a settle timer keeps the retune-safe flag low for a fixed window, so the oscillator frequency is not changed too soon.

Top module: `ratio_clk_div`

## Requirements
- R1: With code 0 the divider stays in bypass. `div_active_o` is 0 and `clk_o` follows `clk_i` in both clock phases.
- R2: A nonzero code N gives an output period of N+1 input cycles. The output is high for the first floor((N+1)/2) cycles of each period, counted from the edge that starts the divider.
- R3: Source code 2'b01 selects the high-speed source. While it is sampled, `div_active_o` is 0 after the next edge.
- R4: Source codes 2'b10 (low-frequency source) and 2'b11 likewise force bypass after the next edge. Only 2'b00 (internal oscillator) permits division.
- R5: `retune_safe_o` is 1 after reset. It is 0 while the divider runs. After the divider turns off it stays 0 for exactly 16 cycles and then returns to 1.
- R6: A nonzero code takes effect only at the 11th edge after `osc_base_i` rises, with `osc_base_i` held high throughout. A drop of `osc_base_i` forces bypass after the next edge and restarts this qualification.
- R7: When `fast_req_blocked_i` is 0 the divider is forced to bypass after the next edge and stays off.
- R8: While the divider runs, a change of a nonzero code is applied only at the end of the current output period.
- R9: While the divider runs, writing code 0 stops it only at the end of the current output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (system) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_code_i | input | 4 | Ratio code: 0 bypass, N divides by N+1 |
| src_sel_i | input | 2 | Selected source: 00 internal oscillator, 01 high-speed, 10 low-frequency |
| fast_req_blocked_i | input | 1 | 1 when asynchronous fast-clock requests are blocked |
| osc_base_i | input | 1 | 1 when the oscillator is at its base frequency |
| clk_o | output | 1 | Divided clock, or `clk_i` in bypass |
| div_active_o | output | 1 | Divider is in the clock path |
| retune_safe_o | output | 1 | Oscillator frequency may be changed |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a 10-cycle base qualification and a 16-cycle settle window. These values keep every ratio from 2 to 16 reachable in a few dozen cycles. The bench measures the even ratios 2 and 16 and the odd ratios 3 and 5 to cover the floor rule for the high phase. The short qualification and settle windows let it sample the exact edge where each one ends, and also the edge one cycle before.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;

    typedef enum logic [1:0] {
        SRC_INT = 2'b00,
        SRC_HS  = 2'b01,
        SRC_LF  = 2'b10,
        SRC_RSV = 2'b11
    } src_sel_e;

endpackage

// File: rtl/ratio_div_base_gate.sv
module ratio_div_base_gate #(
    parameter int BASE_WAIT = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic osc_base_i,
    output logic base_ok_o
);
    localparam int CNT_W = $clog2(BASE_WAIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BASE_WAIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!osc_base_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_ok_o = osc_base_i && (st_q.cnt == CNT_MAX);

endmodule

// File: rtl/ratio_div_core.sv
module ratio_div_core #(
    parameter int CODE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              legal_i,
    output logic              active_o,
    output logic              div_o,
    output logic              stop_o
);
    localparam int RATIO_W = CODE_W + 1;

    typedef struct packed {
        logic               active;
        logic               div;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [RATIO_W-1:0] req_ratio;
    logic [RATIO_W-1:0] cnt_inc;
    logic               period_end;

    assign req_ratio  = {1'b0, code_i} + 1'b1;
    assign cnt_inc    = st_q.cnt + 1'b1;
    assign period_end = (st_q.cnt == st_q.ratio - 1'b1);

    always_comb begin
        st_d = st_q;
        if (!legal_i) begin
            st_d.active = 1'b0;
            st_d.div    = 1'b0;
            st_d.cnt    = '0;
        end else if (!st_q.active) begin
            if (code_i != '0) begin
                st_d.active = 1'b1;
                st_d.ratio  = req_ratio;
                st_d.cnt    = '0;
                st_d.div    = 1'b1;
            end
        end else if (period_end) begin
            st_d.cnt = '0;
            if (code_i == '0) begin
                st_d.active = 1'b0;
                st_d.div    = 1'b0;
            end else begin
                st_d.ratio = req_ratio;
                st_d.div   = 1'b1;
            end
        end else begin
            st_d.cnt = cnt_inc;
            st_d.div = (cnt_inc < (st_q.ratio >> 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign div_o    = st_q.div;
    assign stop_o   = st_q.active && !st_d.active;

endmodule

// File: rtl/ratio_div_settle.sv
module ratio_div_settle #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    input  logic active_i,
    output logic safe_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } settle_st_t;

    settle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign safe_o = !active_i && (st_q.cnt == '0);

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div #(
    parameter int CODE_W        = 4,
    parameter int BASE_WAIT     = 10,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic [1:0]        src_sel_i,
    input  logic              fast_req_blocked_i,
    input  logic              osc_base_i,
    output logic              clk_o,
    output logic              div_active_o,
    output logic              retune_safe_o
);
    import ratio_div_pkg::*;

    logic base_ok;
    logic legal;
    logic active;
    logic div_clk;
    logic stop;

    ratio_div_base_gate #(.BASE_WAIT(BASE_WAIT)) u_base (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .osc_base_i (osc_base_i),
        .base_ok_o  (base_ok)
    );

    assign legal = (src_sel_e'(src_sel_i) == SRC_INT) && fast_req_blocked_i && base_ok;

    ratio_div_core #(.CODE_W(CODE_W)) u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .code_i   (div_code_i),
        .legal_i  (legal),
        .active_o (active),
        .div_o    (div_clk),
        .stop_o   (stop)
    );

    ratio_div_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stop_i   (stop),
        .active_i (active),
        .safe_o   (retune_safe_o)
    );

    assign clk_o        = active ? div_clk : clk_i;
    assign div_active_o = active;

endmodule

// File: rtl/ratio_div_chk.sv
module ratio_div_chk #(
    parameter int CODE_W        = 4,
    parameter int SETTLE_CYCLES = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CODE_W-1:0] div_code_i,
    input logic [1:0]        src_sel_i,
    input logic              fast_req_blocked_i,
    input logic              osc_base_i,
    input logic              div_active_o,
    input logic              retune_safe_o
);
    localparam int WIN_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SETTLE_CYCLES - 1);

    logic             act_prev_q;
    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_prev_q <= 1'b0;
            win_q      <= '0;
        end else begin
            act_prev_q <= div_active_o;
            if (act_prev_q && !div_active_o) begin
                win_q <= WIN_W'(1);
            end else if (win_q != '0 && win_q != WIN_LAST) begin
                win_q <= win_q + 1'b1;
            end else begin
                win_q <= '0;
            end
        end
    end

    assert_zero_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_active_o) |-> ($past(div_code_i) != '0));

    assert_hs_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_sel_i == 2'b01) |=> !div_active_o);

    assert_lf_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_sel_i == 2'b10) |=> !div_active_o);

    assert_run_unsafe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_active_o |-> !retune_safe_o);

    assert_stop_unsafe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(div_active_o) |-> !retune_safe_o);

    assert_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_q != '0) |-> !retune_safe_o);

    assert_base_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_base_i |=> !div_active_o);

    assert_unblocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fast_req_blocked_i |=> !div_active_o);

endmodule

bind ratio_clk_div ratio_div_chk #(
    .CODE_W        (CODE_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .div_code_i         (div_code_i),
    .src_sel_i          (src_sel_i),
    .fast_req_blocked_i (fast_req_blocked_i),
    .osc_base_i         (osc_base_i),
    .div_active_o       (div_active_o),
    .retune_safe_o      (retune_safe_o)
);

// File: tb/sim_ratio_clk_div.sv
`timescale 1ns/1ps
module sim_ratio_clk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = '0;
    logic [1:0] src = 2'b00;
    logic       blocked = 1'b1;
    logic       base = 1'b0;
    logic       clk_out;
    logic       active;
    logic       safe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ratio_clk_div u0 (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .div_code_i         (code),
        .src_sel_i          (src),
        .fast_req_blocked_i (blocked),
        .osc_base_i         (base),
        .clk_o              (clk_out),
        .div_active_o       (active),
        .retune_safe_o      (safe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check_bypass_clock(input string req);
        int bad = 0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            if (clk_out !== 1'b1) bad++;
            @(negedge clk); #1;
            if (clk_out !== 1'b0) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic activate(input int n);
        @(negedge clk);
        code = 4'(n);
        @(negedge clk);
    endtask

    task automatic go_bypass();
        @(negedge clk);
        code = '0;
        for (int i = 0; i < 20 && active; i++) @(negedge clk);
        repeat (17) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(active == 1'b0, "R1 reset active", int'(active), 0);
        chk(safe == 1'b1, "R5 reset safe", int'(safe), 1);
        check_bypass_clock("R1 bypass clock");
    endtask

    task automatic t_base_wait();
        @(negedge clk);
        code = 4'd3; src = 2'b00; blocked = 1'b1; base = 1'b1;
        repeat (10) @(negedge clk);
        chk(active == 1'b0, "R6 before qualification", int'(active), 0);
        @(negedge clk);
        chk(active == 1'b1, "R6 after qualification", int'(active), 1);
        base = 1'b0;
        @(negedge clk);
        chk(active == 1'b0, "R6 base drop", int'(active), 0);
        base = 1'b1;
        repeat (10) @(negedge clk);
        chk(active == 1'b0, "R6 requalify wait", int'(active), 0);
        @(negedge clk);
        chk(active == 1'b1, "R6 requalified", int'(active), 1);
        go_bypass();
    endtask

    task automatic t_ratio(input int n);
        int r = n + 1;
        int bad = 0;
        activate(n);
        for (int i = 0; i < 2 * r; i++) begin
            if (clk_out !== (((i % r) < (r / 2)) ? 1'b1 : 1'b0)) bad++;
            if (active !== 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("R2 ratio %0d", r), bad, 0);
        go_bypass();
    endtask

    task automatic t_stop_settle();
        activate(3);
        code = '0;
        repeat (3) @(negedge clk);
        chk(active == 1'b1, "R9 held to period end", int'(active), 1);
        @(negedge clk);
        chk(active == 1'b0, "R9 stopped at period end", int'(active), 0);
        chk(safe == 1'b0, "R5 window start", int'(safe), 0);
        repeat (15) @(negedge clk);
        chk(safe == 1'b0, "R5 window last cycle", int'(safe), 0);
        @(negedge clk);
        chk(safe == 1'b1, "R5 window over", int'(safe), 1);
    endtask

    task automatic t_ratio_change();
        bit exp [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        int bad = 0;
        activate(3);
        code = 4'd1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (clk_out !== exp[i]) bad++;
        end
        chk(bad == 0, "R8 change at period end", bad, 0);
        go_bypass();
    endtask

    task automatic t_force(input logic [1:0] s, input string req);
        activate(3);
        src = s;
        @(negedge clk);
        chk(active == 1'b0, req, int'(active), 0);
        chk(safe == 1'b0, {req, " unsafe"}, int'(safe), 0);
        check_bypass_clock(req);
        @(negedge clk);
        src = 2'b00;
        go_bypass();
    endtask

    task automatic t_unblock();
        activate(2);
        blocked = 1'b0;
        @(negedge clk);
        chk(active == 1'b0, "R7 forced off", int'(active), 0);
        repeat (5) @(negedge clk);
        chk(active == 1'b0, "R7 stays off", int'(active), 0);
        blocked = 1'b1;
        go_bypass();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base_wait();
        t_ratio(1);
        t_ratio(2);
        t_ratio(4);
        t_ratio(15);
        t_stop_settle();
        go_bypass();
        t_ratio_change();
        t_force(2'b01, "R3 high-speed bypass");
        t_force(2'b10, "R4 low-freq bypass");
        t_force(2'b11, "R4 reserved bypass");
        t_unblock();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule